// File: doc/BRIEF.md
# Two-Tier Rotated-Parity Line Protection Unit

This unit sits between a requester and nine line-wide storage chips and protects every stored line with two layers of redundancy. The first layer is an 8-bit checksum kept next to each line. It lets one chip's read be judged good or bad without touching any other chip. The second layer is one XOR parity line per stripe of eight data lines. It can rebuild any single damaged line of the stripe. The chip that holds the parity line changes from stripe to stripe, so parity updates are spread over all nine chips.

In normal operation a read touches only the chip that holds the requested line. A write reads the old data line and the old parity line, then writes both back with fresh checksums. When a read finds a checksum mismatch, the unit reads the whole stripe and rebuilds the line from the eight other lines. It returns the rebuilt line with a corrected flag and stores the repaired line back. If a second line of the same stripe is also bad, the unit returns an uncorrectable flag instead. A corruption port flips stored bits in one chip, so that fault handling can be exercised through the unit's normal ports.

Top module: `lp_line_guard`

## Requirements
- R1: For stripe s (0..7) the parity line is held by chip 8-s. Data slot k of stripe s is held by chip (8-s+1+k) mod 9. Chip c is bit c of the chip enable vectors.
- R2: A read of a line whose checksum matches enables exactly one chip read, the chip given by R1. It returns the stored line with both flags low, and it writes no chip.
- R3: A write enables reads of exactly the data chip and the parity chip of R1, and then writes exactly those two chips.
- R4: The checksum is the XOR of all bytes of the line. A change to stored bits that leaves this XOR unchanged is not detected: the read returns the altered line with no flag.
- R5: After any sequence of writes, the parity line of a stripe equals the XOR of its eight data lines. This shows as correct rebuilding after writes.
- R6: On a checksum mismatch the unit enables reads of all nine chips. It returns the XOR of the eight other lines with rsp_corrected high and rsp_uncorrectable low.
- R7: A corrected read writes the rebuilt line, with a fresh checksum, back to its own chip only. A later read of that line is clean, as in R2.
- R8: If the requested line and another line of the same stripe both fail their checksums, the read returns the stored requested line with rsp_uncorrectable high, rsp_corrected low, and no chip write.
- R9: Damage to a stripe's parity line has no effect on reads of that stripe's data lines.
- R10: During and after reset, req_ready is high, rsp_valid is low, and no chip enable is asserted. All storage reads as zero with a matching checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_stripe | input | 3 | Stripe index |
| req_slot | input | 3 | Data slot within the stripe |
| req_wdata | input | 64 | Line to write |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| rsp_valid | output | 1 | One-cycle pulse with read result |
| rsp_data | output | 64 | Read line |
| rsp_corrected | output | 1 | Line was rebuilt from parity |
| rsp_uncorrectable | output | 1 | Line could not be rebuilt |
| chip_rd_en | output | 9 | Per-chip read enables |
| chip_wr_en | output | 9 | Per-chip write enables |
| inj_valid | input | 1 | Corrupt a stored line |
| inj_chip | input | 4 | Chip to corrupt |
| inj_stripe | input | 3 | Stripe to corrupt |
| inj_mask | input | 64 | Bits to flip in the stored line, checksum kept |

## Verification
The assertions assume that a request is raised only while req_ready is high. They also assume that corruption is injected only while no request is in flight, and that no line is overwritten while it or its parity line still carries unrepaired corruption. Otherwise the read-modify-write would fold the damage into the parity line. The directed tasks keep within these limits. Each task issues a single request and waits for it to finish. Corruption is injected only between tasks. Every injected fault is either repaired by a corrected read or undone by a second injection of the same mask before any write to that stripe.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int unsigned CSUM_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_FIX   = 2'd2,
    ST_WUPD  = 2'd3
  } lp_state_e;
endpackage

// File: rtl/lp_fold.sv
module lp_fold #(
  parameter int unsigned BYTES = 8
) (
  input  logic [BYTES*8-1:0] line,
  output logic [7:0]         sum
);
  always_comb begin
    sum = '0;
    for (int b = 0; b < int'(BYTES); b++) begin
      sum = sum ^ line[b*8 +: 8];
    end
  end
endmodule

// File: rtl/lp_place.sv
module lp_place #(
  parameter int unsigned DATA_LINES = 8,
  parameter int unsigned STRIPES    = 8,
  localparam int unsigned NCHIPS    = DATA_LINES + 1,
  localparam int unsigned SW        = $clog2(STRIPES),
  localparam int unsigned KW        = $clog2(DATA_LINES),
  localparam int unsigned CW        = $clog2(NCHIPS)
) (
  input  logic [SW-1:0] stripe,
  input  logic [KW-1:0] slot,
  output logic [CW-1:0] par_chip,
  output logic [CW-1:0] dat_chip
);
  logic [31:0] pos_par;
  logic [31:0] pos_dat;

  always_comb begin
    pos_par  = (NCHIPS - 1) - (32'(stripe) % NCHIPS);
    pos_dat  = (pos_par + 32'd1 + 32'(slot)) % NCHIPS;
    par_chip = pos_par[CW-1:0];
    dat_chip = pos_dat[CW-1:0];
  end
endmodule

// File: rtl/lp_chip.sv
module lp_chip #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned WORD_W = DATA_W + lp_pkg::CSUM_W,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word,
  input  logic              flip_en,
  input  logic [AW-1:0]     flip_addr,
  input  logic [DATA_W-1:0] flip_mask
);
  logic [DEPTH-1:0][WORD_W-1:0] mem_q;
  logic [DEPTH-1:0][WORD_W-1:0] mem_n;
  logic [WORD_W-1:0]            rd_n;

  always_comb begin
    mem_n = mem_q;
    if (flip_en) begin
      mem_n[flip_addr] = mem_q[flip_addr] ^ {{lp_pkg::CSUM_W{1'b0}}, flip_mask};
    end
    if (wr_en) begin
      mem_n[addr] = wr_word;
    end
    rd_n = mem_q[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q   <= '0;
      rd_word <= '0;
    end else begin
      if (flip_en || wr_en) mem_q <= mem_n;
      if (rd_en) rd_word <= rd_n;
    end
  end

  AST_NO_RW_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)) else $error("chip read and write in one cycle"); // R7
endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl #(
  parameter int unsigned LINE_BYTES = 8,
  parameter int unsigned DATA_LINES = 8,
  parameter int unsigned STRIPES    = 8,
  localparam int unsigned NCHIPS    = DATA_LINES + 1,
  localparam int unsigned LINE_W    = LINE_BYTES * 8,
  localparam int unsigned WORD_W    = LINE_W + lp_pkg::CSUM_W,
  localparam int unsigned SW        = $clog2(STRIPES),
  localparam int unsigned KW        = $clog2(DATA_LINES),
  localparam int unsigned CW        = $clog2(NCHIPS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [SW-1:0]                  req_stripe,
  input  logic [KW-1:0]                  req_slot,
  input  logic [LINE_W-1:0]              req_wdata,
  output logic                           req_ready,
  output logic                           rsp_valid,
  output logic [LINE_W-1:0]              rsp_data,
  output logic                           rsp_corrected,
  output logic                           rsp_uncorrectable,
  output logic [SW-1:0]                  map_stripe,
  output logic [KW-1:0]                  map_slot,
  input  logic [CW-1:0]                  par_chip,
  input  logic [CW-1:0]                  dat_chip,
  input  logic [NCHIPS-1:0][WORD_W-1:0]  rd_word,
  output logic [NCHIPS-1:0]              chip_rd_en,
  output logic [NCHIPS-1:0]              chip_wr_en,
  output logic [NCHIPS-1:0][WORD_W-1:0]  wr_word
);
  import lp_pkg::*;

  lp_state_e          st_q, st_n;
  logic [SW-1:0]      stripe_q;
  logic [KW-1:0]      slot_q;
  logic [LINE_W-1:0]  wdata_q;
  logic               rsp_valid_q, rsp_valid_n;
  logic [LINE_W-1:0]  rsp_data_q, rsp_data_n;
  logic               corr_q, corr_n;
  logic               unc_q, unc_n;
  logic               accept;

  logic [NCHIPS-1:0][LINE_W-1:0] rd_data;
  logic [NCHIPS-1:0][7:0]        rd_sum;
  logic [NCHIPS-1:0][7:0]        calc_sum;
  logic [NCHIPS-1:0]             sum_ok;

  logic [LINE_W-1:0] rebuilt;
  logic              other_bad;
  logic [LINE_W-1:0] line_sel;
  logic [LINE_W-1:0] new_par;
  logic [7:0]        line_csum;
  logic [7:0]        par_csum;

  // per-chip checksum check
  for (genvar c = 0; c < NCHIPS; c++) begin : g_chk
    assign rd_data[c] = rd_word[c][LINE_W-1:0];
    assign rd_sum[c]  = rd_word[c][WORD_W-1:LINE_W];
    lp_fold #(.BYTES(LINE_BYTES)) u_fold (
      .line (rd_data[c]),
      .sum  (calc_sum[c])
    );
    assign sum_ok[c] = (calc_sum[c] == rd_sum[c]);
  end

  // rebuild from the other eight lines of the stripe
  always_comb begin
    rebuilt   = '0;
    other_bad = 1'b0;
    for (int c = 0; c < int'(NCHIPS); c++) begin
      if (CW'(c) != dat_chip) begin
        rebuilt   = rebuilt ^ rd_data[c];
        other_bad = other_bad | ~sum_ok[c];
      end
    end
  end

  assign line_sel = (st_q == ST_WUPD) ? wdata_q : rebuilt;
  assign new_par  = rd_data[par_chip] ^ rd_data[dat_chip] ^ wdata_q;

  lp_fold #(.BYTES(LINE_BYTES)) u_fold_line (.line(line_sel), .sum(line_csum));
  lp_fold #(.BYTES(LINE_BYTES)) u_fold_par  (.line(new_par),  .sum(par_csum));

  always_comb begin
    for (int c = 0; c < int'(NCHIPS); c++) begin
      if ((st_q == ST_WUPD) && (CW'(c) == par_chip)) wr_word[c] = {par_csum, new_par};
      else                                           wr_word[c] = {line_csum, line_sel};
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign map_stripe = req_ready ? req_stripe : stripe_q;
  assign map_slot   = req_ready ? req_slot   : slot_q;

  // next-state logic
  always_comb begin
    st_n        = st_q;
    chip_rd_en  = '0;
    chip_wr_en  = '0;
    rsp_valid_n = 1'b0;
    rsp_data_n  = rsp_data_q;
    corr_n      = 1'b0;
    unc_n       = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          chip_rd_en[dat_chip] = 1'b1;
          if (req_write) begin
            chip_rd_en[par_chip] = 1'b1;
            st_n = ST_WUPD;
          end else begin
            st_n = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (sum_ok[dat_chip]) begin
          rsp_valid_n = 1'b1;
          rsp_data_n  = rd_data[dat_chip];
          st_n        = ST_IDLE;
        end else begin
          chip_rd_en = '1;
          st_n       = ST_FIX;
        end
      end
      ST_FIX: begin
        rsp_valid_n = 1'b1;
        st_n        = ST_IDLE;
        if (other_bad) begin
          unc_n      = 1'b1;
          rsp_data_n = rd_data[dat_chip];
        end else begin
          corr_n     = 1'b1;
          rsp_data_n = rebuilt;
          chip_wr_en[dat_chip] = 1'b1;
        end
      end
      ST_WUPD: begin
        chip_wr_en[dat_chip] = 1'b1;
        chip_wr_en[par_chip] = 1'b1;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      stripe_q    <= '0;
      slot_q      <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      corr_q      <= 1'b0;
      unc_q       <= 1'b0;
    end else begin
      st_q        <= st_n;
      rsp_valid_q <= rsp_valid_n;
      corr_q      <= corr_n;
      unc_q       <= unc_n;
      if (accept) begin
        stripe_q <= req_stripe;
        slot_q   <= req_slot;
      end
      if (accept && req_write) wdata_q <= req_wdata;
      if (rsp_valid_n) rsp_data_q <= rsp_data_n;
    end
  end

  assign rsp_valid         = rsp_valid_q;
  assign rsp_data          = rsp_data_q;
  assign rsp_corrected     = corr_q;
  assign rsp_uncorrectable = unc_q;

  AST_MAP_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    par_chip != dat_chip) else $error("parity and data share a chip"); // R1
  AST_CHECK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK) |-> $past(accept && !req_write)) else $error("check without read"); // R2
  AST_WRITE_TWO_CHIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WUPD) |-> ($countones(chip_wr_en) == 2)) else $error("write not two chips"); // R3
  AST_FIX_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIX) |-> $past(st_q == ST_CHECK && chip_rd_en == '1)) else $error("rebuild without stripe read"); // R6
  AST_WRITEBACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_corrected |-> ($countones($past(chip_wr_en)) == 1)) else $error("no write-back"); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_corrected, rsp_uncorrectable})) else $error("both flags"); // R8
  AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_corrected || rsp_uncorrectable) |-> rsp_valid) else $error("flag without response"); // R6
  AST_UNC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncorrectable |-> ($past(chip_wr_en) == '0)) else $error("write on uncorrectable"); // R8
endmodule

// File: rtl/lp_line_guard.sv
module lp_line_guard #(
  parameter int unsigned LINE_BYTES = 8,
  parameter int unsigned DATA_LINES = 8,
  parameter int unsigned STRIPES    = 8,
  localparam int unsigned NCHIPS    = DATA_LINES + 1,
  localparam int unsigned LINE_W    = LINE_BYTES * 8,
  localparam int unsigned WORD_W    = LINE_W + lp_pkg::CSUM_W,
  localparam int unsigned SW        = $clog2(STRIPES),
  localparam int unsigned KW        = $clog2(DATA_LINES),
  localparam int unsigned CW        = $clog2(NCHIPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SW-1:0]     req_stripe,
  input  logic [KW-1:0]     req_slot,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_corrected,
  output logic              rsp_uncorrectable,
  output logic [NCHIPS-1:0] chip_rd_en,
  output logic [NCHIPS-1:0] chip_wr_en,
  input  logic              inj_valid,
  input  logic [CW-1:0]     inj_chip,
  input  logic [SW-1:0]     inj_stripe,
  input  logic [LINE_W-1:0] inj_mask
);
  logic [SW-1:0]                 map_stripe;
  logic [KW-1:0]                 map_slot;
  logic [CW-1:0]                 par_chip;
  logic [CW-1:0]                 dat_chip;
  logic [NCHIPS-1:0][WORD_W-1:0] rd_word;
  logic [NCHIPS-1:0][WORD_W-1:0] wr_word;

  lp_place #(.DATA_LINES(DATA_LINES), .STRIPES(STRIPES)) u_place (
    .stripe   (map_stripe),
    .slot     (map_slot),
    .par_chip (par_chip),
    .dat_chip (dat_chip)
  );

  lp_ctrl #(.LINE_BYTES(LINE_BYTES), .DATA_LINES(DATA_LINES), .STRIPES(STRIPES)) u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_valid         (req_valid),
    .req_write         (req_write),
    .req_stripe        (req_stripe),
    .req_slot          (req_slot),
    .req_wdata         (req_wdata),
    .req_ready         (req_ready),
    .rsp_valid         (rsp_valid),
    .rsp_data          (rsp_data),
    .rsp_corrected     (rsp_corrected),
    .rsp_uncorrectable (rsp_uncorrectable),
    .map_stripe        (map_stripe),
    .map_slot          (map_slot),
    .par_chip          (par_chip),
    .dat_chip          (dat_chip),
    .rd_word           (rd_word),
    .chip_rd_en        (chip_rd_en),
    .chip_wr_en        (chip_wr_en),
    .wr_word           (wr_word)
  );

  for (genvar c = 0; c < NCHIPS; c++) begin : g_chip
    logic flip_here;
    assign flip_here = inj_valid && (inj_chip == CW'(c));
    lp_chip #(.DEPTH(STRIPES), .DATA_W(LINE_W)) u_chip (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (chip_rd_en[c]),
      .wr_en     (chip_wr_en[c]),
      .addr      (map_stripe),
      .wr_word   (wr_word[c]),
      .rd_word   (rd_word[c]),
      .flip_en   (flip_here),
      .flip_addr (inj_stripe),
      .flip_mask (inj_mask)
    );
  end

  AST_RESP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready) else $error("response while busy"); // R2
endmodule

// File: tb/lp_line_guard_tb_top.sv
module lp_line_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [2:0]  req_stripe, req_slot;
  logic [63:0] req_wdata;
  logic        req_ready, rsp_valid, rsp_corrected, rsp_uncorrectable;
  logic [63:0] rsp_data;
  logic [8:0]  chip_rd_en, chip_wr_en;
  logic        inj_valid;
  logic [3:0]  inj_chip;
  logic [2:0]  inj_stripe;
  logic [63:0] inj_mask;

  always #10 clk = ~clk;

  lp_line_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_stripe(req_stripe), .req_slot(req_slot), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_corrected(rsp_corrected), .rsp_uncorrectable(rsp_uncorrectable),
    .chip_rd_en(chip_rd_en), .chip_wr_en(chip_wr_en), .inj_valid(inj_valid),
    .inj_chip(inj_chip), .inj_stripe(inj_stripe), .inj_mask(inj_mask)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [63:0] mdl [8][8];
  logic [8:0]  rd_union, wr_union;
  int          rd_cnt;

  always begin
    @(negedge clk);
    #5;
    rd_union = rd_union | chip_rd_en;
    wr_union = wr_union | chip_wr_en;
    rd_cnt   = rd_cnt + $countones(chip_rd_en);
  end

  function automatic int par_of(int s);
    return 8 - (s % 9);
  endfunction
  function automatic int dat_of(int s, int k);
    return (par_of(s) + 1 + k) % 9;
  endfunction
  function automatic logic [8:0] oh(int c);
    return 9'(1) << c;
  endfunction
  function automatic logic [63:0] pat(int s, int k, int seed);
    return {8'(s), 8'(k), 8'(seed), 8'hC3, 8'(s * k + seed), 8'h5A ^ 8'(k), ~8'(s), 8'(seed * 3 + k)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clr_mon();
    rd_union = '0; wr_union = '0; rd_cnt = 0;
  endtask

  task automatic do_write(int s, int k, logic [63:0] d);
    int n = 0;
    @(negedge clk);
    clr_mon();
    req_valid = 1; req_write = 1; req_stripe = 3'(s); req_slot = 3'(k); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    while (!req_ready && n < 20) begin @(negedge clk); n++; end
    mdl[s][k] = d;
    chk(wr_union == (oh(dat_of(s, k)) | oh(par_of(s))), "R3", "write chips",
        64'(wr_union), 64'(oh(dat_of(s, k)) | oh(par_of(s))));
    chk(rd_union == (oh(dat_of(s, k)) | oh(par_of(s))), "R3", "write read chips",
        64'(rd_union), 64'(oh(dat_of(s, k)) | oh(par_of(s))));
  endtask

  task automatic do_read(int s, int k, logic [63:0] exp, bit ec, bit eu, bit eall, string req);
    int n = 0;
    logic [8:0] exp_rd, exp_wr;
    @(negedge clk);
    clr_mon();
    req_valid = 1; req_write = 0; req_stripe = 3'(s); req_slot = 3'(k);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    exp_rd = eall ? 9'h1FF : oh(dat_of(s, k));
    exp_wr = ec ? oh(dat_of(s, k)) : 9'h000;
    chk(rsp_valid && rsp_data == exp, req, "read data", rsp_data, exp);
    chk(rsp_corrected == ec && rsp_uncorrectable == eu, req, "flags",
        64'({rsp_corrected, rsp_uncorrectable}), 64'({ec, eu}));
    chk(rd_union == exp_rd, req, "read chips", 64'(rd_union), 64'(exp_rd));
    if (!eall) chk(rd_cnt == 1, req, "read count", 64'(rd_cnt), 64'd1);
    chk(wr_union == exp_wr, req, "write-back chips", 64'(wr_union), 64'(exp_wr));
  endtask

  task automatic inject(int c, int s, logic [63:0] m);
    @(negedge clk);
    inj_valid = 1; inj_chip = 4'(c); inj_stripe = 3'(s); inj_mask = m;
    @(negedge clk);
    inj_valid = 0;
  endtask

  task automatic t_reset();
    #5;
    chk(req_ready == 1'b1, "R10", "ready in reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R10", "valid in reset", 64'(rsp_valid), 64'd0);
    chk(chip_rd_en == 9'd0 && chip_wr_en == 9'd0, "R10", "enables in reset",
        64'({chip_rd_en, chip_wr_en}), 64'd0);
  endtask

  task automatic t_zero_read();
    do_read(4, 6, 64'd0, 0, 0, 0, "R10");
  endtask

  task automatic t_fill();
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 8; k++) do_write(s, k, pat(s, k, 1));
  endtask

  task automatic t_clean_all();
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 8; k++) do_read(s, k, mdl[s][k], 0, 0, 0, "R1");
  endtask

  task automatic t_every_chip();
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 9; c++) begin
        logic [63:0] m = 64'h81 << (8 * ((s + c) % 8));
        if (c == par_of(s)) begin
          inject(c, s, m);
          do_read(s, 0, mdl[s][0], 0, 0, 0, "R9");
          do_read(s, 7, mdl[s][7], 0, 0, 0, "R9");
          inject(c, s, m);
        end else begin
          int k = (c - par_of(s) - 1 + 9) % 9;
          inject(c, s, m);
          do_read(s, k, mdl[s][k], 1, 0, 1, "R6");
          do_read(s, k, mdl[s][k], 0, 0, 0, "R7");
        end
      end
    end
  endtask

  task automatic t_undetected();
    logic [63:0] m = 64'h0000_0000_0000_0101;
    inject(dat_of(2, 3), 2, m);
    do_read(2, 3, mdl[2][3] ^ m, 0, 0, 0, "R4");
    inject(dat_of(2, 3), 2, m);
    do_read(2, 3, mdl[2][3], 0, 0, 0, "R4");
  endtask

  task automatic t_double();
    logic [63:0] m0 = 64'h0000_0000_0000_0010;
    logic [63:0] m1 = 64'h0000_0200_0000_0000;
    inject(dat_of(3, 0), 3, m0);
    inject(dat_of(3, 1), 3, m1);
    do_read(3, 0, mdl[3][0] ^ m0, 0, 1, 1, "R8");
    inject(dat_of(3, 0), 3, m0);
    inject(dat_of(3, 1), 3, m1);
    do_read(3, 0, mdl[3][0], 0, 0, 0, "R8");
    do_read(3, 1, mdl[3][1], 0, 0, 0, "R8");
  endtask

  task automatic t_write_rebuild();
    do_write(5, 2, 64'hDEAD_BEEF_0123_4567);
    do_write(5, 6, 64'hFFFF_0000_FFFF_0000);
    do_write(5, 2, 64'h1357_9BDF_2468_ACE0);
    do_write(5, 0, 64'h0);
    for (int k = 0; k < 8; k++) begin
      inject(dat_of(5, k), 5, 64'h4000_0000_0000_0001);
      do_read(5, k, mdl[5][k], 1, 0, 1, "R5");
    end
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_stripe = '0; req_slot = '0;
    req_wdata = '0; inj_valid = 0; inj_chip = '0; inj_stripe = '0; inj_mask = '0;
    clr_mon();
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 8; k++) mdl[s][k] = '0;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_zero_read();
    t_fill();
    t_clean_all();
    t_every_chip();
    t_undetected();
    t_double();
    t_write_rebuild();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule